// File: doc/BRIEF.md
# Statically Routed Unit Interconnect with Request Flow Control

This block is the switch fabric that links the processing units of a signal-processing subsystem (data memories, hardware accelerators and external interfaces). Each attached unit owns exactly one write port, where it produces data, and one read port, where it consumes data. The core sets each path with a configuration command: for a given read port it names which write port feeds it. There is no arbitration and no address decoding, so a configured path passes data with no setup cost per item.

Transfers are pulled by the consumer. A consumer asserts a one-cycle request for each item it wants. The producer answers with a one-cycle data-available strobe in the cycle its data is valid. A consumer-side handshake controller, instantiated once per read port, turns a unit's "pull" wish into request pulses. It tracks how many requests are still unanswered and halts at two. With a producer that answers one cycle later, this still moves one item per cycle.

A source can be owned by only one consumer at a time. Connecting a new consumer to a source drops the old consumer's path, which is how a memory is handed from one unit to another.

Top module: `xbar_link_net`

## Requirements
- R1: During reset and after its release, and before any configuration, every read port is unconnected. `wr_req`, `rd_avail`, `rd_data` and `rd_stall` are all zero whatever `rd_pull` and `wr_avail` do.
- R2: A configuration command (`cfg_we` high, with `cfg_dst` naming the read port, `cfg_src` naming the write port and `cfg_en` giving the connect bit) takes effect on the clock edge that samples it. The new path is visible from the following cycle, and not in the command cycle itself.
- R3: On a connected read port d with source s, `rd_avail[d]` equals `wr_avail[s]` and `rd_data` lane d equals `wr_data` lane s in the same cycle. Lane k is bits k*DW to k*DW+DW-1.
- R4: A pull on a connected read port with fewer than two requests outstanding raises `wr_req[s]` of its source in the same cycle. No other write port sees a request.
- R5: A read port never has more than two requests outstanding. With two outstanding, a pull produces no request and `rd_stall` of that port is 1.
- R6: Each data-available on a port with requests outstanding lowers its count by one. A producer that answers every request one cycle later sustains one request and one item every cycle, without stalling.
- R7: An unconnected read port shows `rd_avail` 0 and `rd_data` 0. A write port that no connected read port selects never sees `wr_req`.
- R8: Connecting read port d to source s disconnects every other read port that was connected to s, so at most one read port owns a source.
- R9: A read port touched by a configuration command (addressed or displaced) issues no request in the command cycle. Its outstanding count is zero afterwards.
- R10: A command with `cfg_en` 0 disconnects the addressed read port.
- R11: A data-available arriving with no request outstanding leaves the count at zero. The port can then still issue two requests before it stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration command strobe |
| cfg_dst | input | $clog2(NPORT) | Read port addressed by the command |
| cfg_src | input | $clog2(NPORT) | Write port chosen as source |
| cfg_en | input | 1 | 1 connects, 0 disconnects |
| wr_data | input | NPORT*DW | Producer data, one DW-bit lane per write port |
| wr_avail | input | NPORT | Producer data-available strobes |
| wr_req | output | NPORT | Requests routed to producers |
| rd_pull | input | NPORT | Consumer wishes to fetch an item this cycle |
| rd_data | output | NPORT*DW | Routed data, one lane per read port |
| rd_avail | output | NPORT | Routed data-available strobes |
| rd_stall | output | NPORT | Read port has two requests outstanding |

## Verification
The bench sweeps all 64 pairings of read port and source, with a producer model that answers every request a cycle later. It checks the same-cycle request routing, the one-item-per-cycle stream and the values carried. A routing mux with swapped indices, or a request path left open to other ports, would show the wrong lane or stray requests. It then holds the producer back to drive the outstanding count to its ceiling, where a count that wraps or saturates wrongly would keep requesting or stall early. It also checks the release on each strobe. Spurious strobes with nothing outstanding are there to catch an underflow. Reconfiguring in the middle of a stream must both hold off the request in the command cycle and clear the count. Stealing a source must silence the old owner.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  // outstanding-request counter of one read port
  typedef logic [1:0] pend_t;
  localparam pend_t PEND_MAX = 2'd2;
endpackage

// File: rtl/xbar_cfg_regs.sv
`timescale 1ns/1ps
module xbar_cfg_regs #(
  parameter int NPORT = 8,
  parameter int SELW  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SELW-1:0]            cfg_dst,
  input  logic [SELW-1:0]            cfg_src,
  input  logic                       cfg_en,
  output logic [NPORT-1:0]           conn_en,
  output logic [NPORT-1:0][SELW-1:0] conn_sel,
  output logic [NPORT-1:0]           port_clr
);
  logic [NPORT-1:0]           en_q, en_d;
  logic [NPORT-1:0][SELW-1:0] sel_q, sel_d;
  logic [NPORT-1:0]           hit, steal;

  // next state: addressed port takes the command, other owners of the source let go
  always_comb begin
    for (int e = 0; e < NPORT; e++) begin
      hit[e]   = cfg_we && (cfg_dst == SELW'(e));
      steal[e] = cfg_we && cfg_en && !hit[e] && en_q[e] && (sel_q[e] == cfg_src);
      en_d[e]  = hit[e] ? cfg_en : (steal[e] ? 1'b0 : en_q[e]);
      sel_d[e] = hit[e] ? cfg_src : sel_q[e];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else if (cfg_we) begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  assign conn_en  = en_q;
  assign conn_sel = sel_q;
  assign port_clr = hit | steal;

  // a command lands on the addressed port
  assert_cfg_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q[$past(cfg_dst)] == $past(cfg_en)) &&
               (sel_q[$past(cfg_dst)] == $past(cfg_src)));

  // each source owned by at most one read port
  for (genvar s = 0; s < NPORT; s++) begin : g_own
    logic [NPORT-1:0] owners;
    always_comb begin
      for (int e = 0; e < NPORT; e++)
        owners[e] = en_q[e] && (sel_q[e] == SELW'(s));
    end
    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owners));
  end
endmodule

// File: rtl/xbar_rd_ctl.sv
`timescale 1ns/1ps
module xbar_rd_ctl
  import xbar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_en,
  input  logic clr,
  input  logic pull,
  input  logic avail,
  output logic req,
  output logic stall
);
  pend_t cnt_q, cnt_d;
  logic  dec, upd;

  assign req   = pull && link_en && !clr && (cnt_q < PEND_MAX);
  assign dec   = avail && (cnt_q != '0);
  assign stall = link_en && (cnt_q == PEND_MAX);
  assign upd   = clr || req || dec;

  always_comb begin
    if (clr)             cnt_d = '0;
    else if (req && !dec) cnt_d = cnt_q + pend_t'(1);
    else if (!req && dec) cnt_d = cnt_q - pend_t'(1);
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assert_no_req_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == PEND_MAX) |-> !req);

  assert_cnt_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && req && !avail) |=> (cnt_q == pend_t'($past(cnt_q) + 2'd1)));

  assert_cnt_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !req && avail && cnt_q != '0) |=> (cnt_q == pend_t'($past(cnt_q) - 2'd1)));

  assert_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !req && avail && cnt_q == '0) |=> (cnt_q == '0));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/xbar_route.sv
`timescale 1ns/1ps
module xbar_route #(
  parameter int NPORT = 8,
  parameter int DW    = 16,
  parameter int SELW  = 3
) (
  input  logic [NPORT-1:0]           conn_en,
  input  logic [NPORT-1:0][SELW-1:0] conn_sel,
  input  logic [NPORT-1:0][DW-1:0]   src_data,
  input  logic [NPORT-1:0]           src_avail,
  input  logic [NPORT-1:0]           dst_req,
  output logic [NPORT-1:0][DW-1:0]   dst_data,
  output logic [NPORT-1:0]           dst_avail,
  output logic [NPORT-1:0]           src_req
);
  // forward direction: one mux per read port
  for (genvar d = 0; d < NPORT; d++) begin : g_fwd
    assign dst_avail[d] = conn_en[d] && src_avail[conn_sel[d]];
    assign dst_data[d]  = conn_en[d] ? src_data[conn_sel[d]] : '0;
  end

  // reverse direction: requests steered back to the selected source
  always_comb begin
    src_req = '0;
    for (int d = 0; d < NPORT; d++)
      if (conn_en[d] && dst_req[d]) src_req[conn_sel[d]] = 1'b1;
  end
endmodule

// File: rtl/xbar_link_net.sv
`timescale 1ns/1ps
module xbar_link_net #(
  parameter int NPORT = 8,
  parameter int DW    = 16,
  localparam int SELW = $clog2(NPORT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SELW-1:0]       cfg_dst,
  input  logic [SELW-1:0]       cfg_src,
  input  logic                  cfg_en,
  input  logic [NPORT*DW-1:0]   wr_data,
  input  logic [NPORT-1:0]      wr_avail,
  output logic [NPORT-1:0]      wr_req,
  input  logic [NPORT-1:0]      rd_pull,
  output logic [NPORT*DW-1:0]   rd_data,
  output logic [NPORT-1:0]      rd_avail,
  output logic [NPORT-1:0]      rd_stall
);
  logic [1:0]                 rst_sync_q;
  logic                       rst_n_i;
  logic [NPORT-1:0]           conn_en, port_clr, dst_req;
  logic [NPORT-1:0][SELW-1:0] conn_sel;
  logic [NPORT-1:0][DW-1:0]   src_data, dst_data;

  // reset: asserts at once, lifts two edges after the pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  xbar_cfg_regs #(.NPORT(NPORT), .SELW(SELW)) i_cfg (
    .clk(clk), .rst_n(rst_n_i), .cfg_we(cfg_we), .cfg_dst(cfg_dst),
    .cfg_src(cfg_src), .cfg_en(cfg_en), .conn_en(conn_en),
    .conn_sel(conn_sel), .port_clr(port_clr)
  );

  for (genvar d = 0; d < NPORT; d++) begin : g_ctl
    xbar_rd_ctl i_ctl (
      .clk(clk), .rst_n(rst_n_i), .link_en(conn_en[d]), .clr(port_clr[d]),
      .pull(rd_pull[d]), .avail(rd_avail[d]), .req(dst_req[d]),
      .stall(rd_stall[d])
    );
  end

  assign src_data = wr_data;

  xbar_route #(.NPORT(NPORT), .DW(DW), .SELW(SELW)) i_route (
    .conn_en(conn_en), .conn_sel(conn_sel), .src_data(src_data),
    .src_avail(wr_avail), .dst_req(dst_req), .dst_data(dst_data),
    .dst_avail(rd_avail), .src_req(wr_req)
  );

  assign rd_data = dst_data;

  for (genvar d = 0; d < NPORT; d++) begin : g_chk
    assert_unconn_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
      !conn_en[d] |-> (!rd_avail[d] && rd_data[d*DW +: DW] == '0 && !rd_stall[d]));
  end
endmodule

// File: tb/test_xbar_link_net.sv
`timescale 1ns/1ps
module test_xbar_link_net;
  localparam int NP = 8;
  localparam int DW = 16;
  localparam int SW = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we, cfg_en;
  logic [SW-1:0]     cfg_dst, cfg_src;
  logic [NP*DW-1:0]  wr_data;
  logic [NP-1:0]     wr_avail, wr_req, rd_pull, rd_avail, rd_stall;
  logic [NP*DW-1:0]  rd_data;

  logic              prod_auto;
  logic [NP-1:0]     prod_avail, man_avail;
  logic [NP-1:0][DW-1:0] prod_data;
  logic [11:0]       prod_ctr [NP];
  int                exp_ctr [NP];
  int                n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  xbar_link_net #(.NPORT(NP), .DW(DW)) i_xbar_link_net (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dst(cfg_dst),
    .cfg_src(cfg_src), .cfg_en(cfg_en), .wr_data(wr_data),
    .wr_avail(wr_avail), .wr_req(wr_req), .rd_pull(rd_pull),
    .rd_data(rd_data), .rd_avail(rd_avail), .rd_stall(rd_stall)
  );

  // producer model: answers each request one cycle later with {port, count}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_avail <= '0;
      prod_data  <= '0;
      for (int s = 0; s < NP; s++) prod_ctr[s] <= '0;
    end else begin
      for (int s = 0; s < NP; s++) begin
        prod_avail[s] <= prod_auto && wr_req[s];
        if (prod_auto && wr_req[s]) begin
          prod_data[s] <= {4'(s), prod_ctr[s]};
          prod_ctr[s]  <= prod_ctr[s] + 12'd1;
        end
      end
    end
  end
  assign wr_avail = prod_avail | man_avail;
  assign wr_data  = prod_data;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int d, input int s, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dst = SW'(d); cfg_src = SW'(s); cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [NP-1:0] bit1(input int k);
    return NP'(1) << k;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_en = 1'b0; cfg_dst = '0; cfg_src = '0;
    rd_pull = '0; man_avail = '0; prod_auto = 1'b0;
    for (int s = 0; s < NP; s++) exp_ctr[s] = 0;
    prev = '0;

    // R1: quiet in and after reset
    repeat (3) @(negedge clk);
    rd_pull = '1; man_avail = '1;
    #1;
    chk("R1 wr_req in reset", wr_req, 0);
    chk("R1 rd_avail in reset", rd_avail, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 wr_req", wr_req, 0);
    chk("R1 rd_avail", rd_avail, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rd_stall", rd_stall, 0);
    rd_pull = '0; man_avail = '0;

    // R2: command not visible in its own cycle, visible after
    @(negedge clk);
    cfg_we = 1'b1; cfg_dst = 3'd1; cfg_src = 3'd2; cfg_en = 1'b1;
    man_avail = bit1(2);
    #1 chk("R2 before edge", rd_avail, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1 chk("R2 after edge", rd_avail, bit1(1));
    man_avail = '0;
    cfg(1, 2, 1'b0);

    // R3 R4 R6 R7: sweep every read port against every source
    prod_auto = 1'b1;
    for (int d = 0; d < NP; d++) begin
      for (int s = 0; s < NP; s++) begin
        cfg(d, s, 1'b1);
        for (int i = 0; i < 4; i++) begin
          rd_pull[d] = 1'b1;
          #1;
          chk($sformatf("R4 req d%0d s%0d", d, s), wr_req, bit1(s));
          chk($sformatf("R6 no stall d%0d", d), rd_stall, 0);
          if (i > 0) begin
            chk($sformatf("R7 avail only d%0d s%0d", d, s), rd_avail, bit1(d));
            chk($sformatf("R3 data d%0d s%0d", d, s), rd_data[d*DW +: DW], prev);
          end
          prev = {4'(s), 12'(exp_ctr[s])};
          exp_ctr[s]++;
          @(negedge clk);
        end
        rd_pull[d] = 1'b0;
        #1;
        chk($sformatf("R4 idle d%0d", d), wr_req, 0);
        chk($sformatf("R6 last avail d%0d", d), rd_avail, bit1(d));
        chk($sformatf("R3 last data d%0d s%0d", d, s), rd_data[d*DW +: DW], prev);
        @(negedge clk);
        #1 chk($sformatf("R6 drained d%0d", d), rd_avail, 0);
        cfg(d, s, 1'b0);
      end
    end
    prod_auto = 1'b0;

    // R8: stealing a source silences the old owner
    cfg(0, 4, 1'b1);
    cfg(6, 4, 1'b1);
    rd_pull[0] = 1'b1;
    #1 chk("R8 old owner no req", wr_req, 0);
    rd_pull[0] = 1'b0; rd_pull[6] = 1'b1;
    #1 chk("R8 new owner req", wr_req, bit1(4));
    rd_pull[6] = 1'b0; man_avail = bit1(4);
    #1 chk("R8 avail to new owner", rd_avail, bit1(6));
    man_avail = '0;

    // R10: disconnect
    cfg(6, 4, 1'b0);
    rd_pull[6] = 1'b1; man_avail = '1;
    #1;
    chk("R10 no req", wr_req, 0);
    chk("R10 no avail", rd_avail, 0);
    chk("R10 no data", rd_data, 0);
    rd_pull = '0; man_avail = '0;

    // R5 R6: ceiling of two, release per strobe
    cfg(2, 5, 1'b1);
    rd_pull[2] = 1'b1;
    #1 chk("R4 first req", wr_req, bit1(5));
    @(negedge clk);
    #1 chk("R5 second req", wr_req, bit1(5));
    @(negedge clk);
    #1;
    chk("R5 held at two", wr_req, 0);
    chk("R5 stall", rd_stall, bit1(2));
    @(negedge clk);
    man_avail = bit1(5);
    #1;
    chk("R5 still held", wr_req, 0);
    chk("R3 strobe routed", rd_avail, bit1(2));
    @(negedge clk);
    man_avail = '0;
    #1;
    chk("R6 slot freed", wr_req, bit1(5));
    chk("R6 stall off", rd_stall, 0);
    @(negedge clk);
    #1 chk("R5 full again", rd_stall, bit1(2));
    rd_pull = '0;

    // R9: reconfiguration clears the count and holds off the command cycle
    cfg(2, 5, 1'b1);
    rd_pull[2] = 1'b1;
    #1 chk("R9 count cleared", wr_req, bit1(5));
    @(negedge clk);
    rd_pull[2] = 1'b0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_dst = 3'd2; cfg_src = 3'd5; cfg_en = 1'b1;
    rd_pull[2] = 1'b1;
    #1 chk("R9 holdoff", wr_req, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1 chk("R9 after clear req", wr_req, bit1(5));
    @(negedge clk);
    #1 chk("R9 second req", wr_req, bit1(5));
    @(negedge clk);
    #1 chk("R5 stall after two", rd_stall, bit1(2));
    rd_pull = '0;

    // R11: strobe with nothing outstanding
    cfg(3, 1, 1'b1);
    man_avail = bit1(1);
    #1 chk("R11 spurious routed", rd_avail, bit1(3));
    @(negedge clk);
    man_avail = '0; rd_pull[3] = 1'b1;
    #1 chk("R11 first req", wr_req, bit1(1));
    @(negedge clk);
    #1 chk("R11 second req", wr_req, bit1(1));
    @(negedge clk);
    #1;
    chk("R11 then held", wr_req, 0);
    chk("R11 stall", rd_stall, bit1(2) | bit1(3));
    rd_pull = '0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule